// File: doc/BRIEF.md
# Bit-Rate Smoothing Elastic Buffer

This block sits in the data path of a 2.048 Mb/s line and removes jitter. It accepts single bits on an input strobe that may come in bursts with gaps between them. It returns the bits on an output strobe whose spacing is even. Everything runs on one 32.768 MHz clock, and both strobes are one-cycle enables in that clock domain. At the nominal rate the output strobe fires once every 16 cycles.

The buffer depth can be 32 bits, which gives low delay, or 128 bits, which tolerates wide wander. The block tracks how far the buffer has filled, measured from the midpoint. When the fill strays far from the midpoint, the block shortens the output period to 15 cycles or lengthens it to 17. A sticky status flag records each such correction, and the host clears it with a one-cycle pulse. A bypass input takes the buffer out of the path entirely.

Top module: `jitter_elastic_buf`

## Requirements
- R1: `cfg_deep`=1 selects a 128-bit buffer with a tolerance of 120 bits. `cfg_deep`=0 selects a 32-bit buffer with a tolerance of 28 bits. The same input pattern, bursts of 40 writes every 640 cycles, sets `trip_flag` in the 32-bit mode. In the 128-bit mode it leaves `trip_flag` clear.
- R2: While `cfg_bypass`=1, `out_stb` and `out_bit` repeat `in_stb` and `in_bit` one cycle later. In this mode `ovf_evt` and `unf_evt` stay 0.
- R3: While the fill stays between the two limits, successive `out_stb` pulses are exactly 16 cycles apart.
- R4: A fill above half the depth plus half the tolerance selects a 15-cycle period. That limit is above 124 bits in the 128-bit mode and above 30 bits in the 32-bit mode.
- R5: A fill below half the depth minus half the tolerance selects a 17-cycle period. That limit is below 4 bits in the 128-bit mode and below 2 bits in the 32-bit mode.
- R6: `trip_flag` is 0 after reset. It goes to 1 on the cycle that `out_stb` starts any period of 15 or 17 cycles.
- R7: `trip_flag` is sticky. A one-cycle `trip_clr` pulse clears it. If a new correction occurs in the same cycle as the clear, the flag stays 1.
- R8: Reset, any change of `cfg_deep` and any change of `cfg_bypass` each recentre the buffer. The fill restarts at half the depth and the period counter restarts.
- R9: A write into a full buffer overwrites the oldest bit and pulses `ovf_evt` for one cycle. The fill stays at the full depth.
- R10: A read from an empty buffer repeats the previous `out_bit` and pulses `unf_evt` together with `out_stb`.
- R11: With no overflow or underflow, bits leave in the order they were written, whatever the gaps between input strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_deep | input | 1 | 1: 128-bit buffer, 0: 32-bit buffer |
| cfg_bypass | input | 1 | 1: buffer removed from the path |
| in_stb | input | 1 | Input bit strobe (clock enable) |
| in_bit | input | 1 | Input data bit |
| trip_clr | input | 1 | One-cycle clear of the trip flag |
| out_stb | output | 1 | Smoothed output bit strobe |
| out_bit | output | 1 | Output data bit, valid with `out_stb` |
| trip_flag | output | 1 | Sticky flag: period was adjusted |
| ovf_evt | output | 1 | One-cycle pulse: full-buffer overwrite |
| unf_evt | output | 1 | One-cycle pulse: empty-buffer read |

## Verification
Steady writes every 16 cycles show the nominal period. Bursts of 8 writes every 128 cycles test bit order under gapped input without triggering a correction. Bursts of 40 writes every 640 cycles are run in both depths: they overflow the 32-bit buffer and fit in the 128-bit one, so this pattern shows which depth and limits are in force. A write on every cycle drives the fill to the top and shows the 15-cycle period and overwrite pulses. No writes at all drain the buffer and show the 17-cycle period and the repeated bit. Toggling the bypass recentres the fill, and the bench checks the clear pulse both against an idle cycle and against a cycle that also raises the flag.

// File: rtl/jeb_pkg.sv
package jeb_pkg;
  typedef enum logic [1:0] {
    DIV_NOM  = 2'd0,
    DIV_FAST = 2'd1,
    DIV_SLOW = 2'd2
  } div_pick_e;
endpackage

// File: rtl/jeb_bitram.sv
module jeb_bitram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  // write port, no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first registered read port; holds its value when not enabled
  always_ff @(posedge clk) begin
    if (rst)     rdata <= 1'b0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/jeb_fill_ctrl.sv
module jeb_fill_ctrl
  import jeb_pkg::*;
#(
  parameter int DEEP_DEPTH    = 128,
  parameter int SHALLOW_DEPTH = 32,
  parameter int DEEP_TOL      = 120,
  parameter int SHALLOW_TOL   = 28,
  localparam int AW = $clog2(DEEP_DEPTH),
  localparam int FW = $clog2(DEEP_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          deep,
  input  logic          active,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_take,
  output div_pick_e     pick,
  output logic          ovf_pulse,
  output logic          unf_pulse
);
  localparam int HI_DEEP = DEEP_DEPTH / 2 + DEEP_TOL / 2;
  localparam int LO_DEEP = DEEP_DEPTH / 2 - DEEP_TOL / 2;
  localparam int HI_SHAL = SHALLOW_DEPTH / 2 + SHALLOW_TOL / 2;
  localparam int LO_SHAL = SHALLOW_DEPTH / 2 - SHALLOW_TOL / 2;

  logic [FW-1:0] fill;
  logic [FW-1:0] cur_depth;
  logic [FW-1:0] half_depth;
  logic [FW-1:0] hi_lim;
  logic [FW-1:0] lo_lim;
  logic [AW-1:0] ptr_mask;
  logic          do_wr;
  logic          do_rd;
  logic          empty;
  logic          full;
  logic          ovw;

  always_comb begin
    cur_depth  = deep ? FW'(DEEP_DEPTH) : FW'(SHALLOW_DEPTH);
    half_depth = cur_depth >> 1;
    ptr_mask   = deep ? AW'(DEEP_DEPTH - 1) : AW'(SHALLOW_DEPTH - 1);
    hi_lim     = deep ? FW'(HI_DEEP) : FW'(HI_SHAL);
    lo_lim     = deep ? FW'(LO_DEEP) : FW'(LO_SHAL);
  end

  assign do_wr   = active && wr_en;
  assign do_rd   = active && rd_en;
  assign empty   = (fill == '0);
  assign full    = (fill == cur_depth);
  assign rd_take = do_rd && !empty;
  assign ovw     = do_wr && full && !rd_take;

  always_comb begin
    if (fill > hi_lim)      pick = DIV_FAST;
    else if (fill < lo_lim) pick = DIV_SLOW;
    else                    pick = DIV_NOM;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wr_addr   <= AW'(half_depth);
      rd_addr   <= '0;
      fill      <= half_depth;
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      if (do_wr) wr_addr <= (wr_addr + AW'(1)) & ptr_mask;
      if (rd_take || ovw) rd_addr <= (rd_addr + AW'(1)) & ptr_mask;
      if (!ovw) begin
        if (do_wr && !rd_take)      fill <= fill + FW'(1);
        else if (!do_wr && rd_take) fill <= fill - FW'(1);
      end
      ovf_pulse <= ovw;
      unf_pulse <= do_rd && empty;
    end
  end

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    !restart |=> fill <= $past(cur_depth));

  p_ovw_holds_full_r9: assert property (@(posedge clk) disable iff (rst)
    (ovw && !restart) |=> (fill == $past(fill)) && ovf_pulse);

  p_unf_stays_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (do_rd && empty && !do_wr && !restart) |=> (fill == '0) && unf_pulse);

  p_restart_centres_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> fill == $past(half_depth));
endmodule

// File: rtl/jeb_rate_div.sv
module jeb_rate_div
  import jeb_pkg::*;
#(
  parameter int NOM_DIV = 16,
  localparam int CW = $clog2(NOM_DIV + 2)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      run,
  input  div_pick_e pick,
  output logic      fire,
  output logic      adjust
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_div;

  assign fire   = run && (cnt == cur_div - CW'(1));
  assign adjust = fire && (pick != DIV_NOM);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt     <= '0;
      cur_div <= CW'(NOM_DIV);
    end else if (!run) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= '0;
      case (pick)
        DIV_FAST: cur_div <= CW'(NOM_DIV - 1);
        DIV_SLOW: cur_div <= CW'(NOM_DIV + 1);
        default:  cur_div <= CW'(NOM_DIV);
      endcase
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  p_fast_shortens_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && pick == DIV_FAST && !restart) |=> cur_div == CW'(NOM_DIV - 1));

  p_slow_lengthens_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && pick == DIV_SLOW && !restart) |=> cur_div == CW'(NOM_DIV + 1));

  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/jeb_trip_latch.sv
module jeb_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/jitter_elastic_buf.sv
module jitter_elastic_buf
  import jeb_pkg::*;
#(
  parameter int DEEP_DEPTH    = 128,
  parameter int SHALLOW_DEPTH = 32,
  parameter int DEEP_TOL      = 120,
  parameter int SHALLOW_TOL   = 28,
  parameter int NOM_DIV       = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_deep,
  input  logic cfg_bypass,
  input  logic in_stb,
  input  logic in_bit,
  input  logic trip_clr,
  output logic out_stb,
  output logic out_bit,
  output logic trip_flag,
  output logic ovf_evt,
  output logic unf_evt
);
  localparam int AW = $clog2(DEEP_DEPTH);

  logic          deep_q;
  logic          byp_q;
  logic          byp_stb_q;
  logic          byp_bit_q;
  logic          rd_stb_q;
  logic          restart;
  logic          div_fire;
  logic          div_adj;
  logic          rd_take;
  logic          ram_q;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  div_pick_e     pick;

  assign restart = (cfg_deep != deep_q) || (cfg_bypass != byp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      deep_q    <= cfg_deep;
      byp_q     <= cfg_bypass;
      byp_stb_q <= 1'b0;
      byp_bit_q <= 1'b0;
      rd_stb_q  <= 1'b0;
    end else begin
      deep_q    <= cfg_deep;
      byp_q     <= cfg_bypass;
      byp_stb_q <= in_stb && cfg_bypass;
      byp_bit_q <= in_bit;
      rd_stb_q  <= div_fire;
    end
  end

  jeb_fill_ctrl #(
    .DEEP_DEPTH   (DEEP_DEPTH),
    .SHALLOW_DEPTH(SHALLOW_DEPTH),
    .DEEP_TOL     (DEEP_TOL),
    .SHALLOW_TOL  (SHALLOW_TOL)
  ) u_fill (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .deep     (cfg_deep),
    .active   (!cfg_bypass),
    .wr_en    (in_stb),
    .rd_en    (div_fire),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .rd_take  (rd_take),
    .pick     (pick),
    .ovf_pulse(ovf_evt),
    .unf_pulse(unf_evt)
  );

  jeb_bitram #(.DEPTH(DEEP_DEPTH)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (in_stb && !cfg_bypass && !restart),
    .waddr(wr_addr),
    .wdata(in_bit),
    .re   (rd_take && !restart),
    .raddr(rd_addr),
    .rdata(ram_q)
  );

  jeb_rate_div #(.NOM_DIV(NOM_DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .run    (!cfg_bypass),
    .pick   (pick),
    .fire   (div_fire),
    .adjust (div_adj)
  );

  jeb_trip_latch u_trip (
    .clk (clk),
    .rst (rst),
    .set (div_adj),
    .clr (trip_clr),
    .flag(trip_flag)
  );

  assign out_stb = byp_q ? byp_stb_q : rd_stb_q;
  assign out_bit = byp_q ? byp_bit_q : ram_q;

  p_trip_on_adjust_r6: assert property (@(posedge clk) disable iff (rst)
    div_adj |=> trip_flag && out_stb);

  p_clear_drops_trip_r7: assert property (@(posedge clk) disable iff (rst)
    (trip_clr && !div_adj) |=> !trip_flag);

  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_bypass && !restart) |=> !ovf_evt && !unf_evt);
endmodule

// File: tb/test_jitter_elastic_buf.sv
module test_jitter_elastic_buf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_deep = 1'b0;
  logic cfg_bypass = 1'b0;
  logic in_stb = 1'b0;
  logic in_bit = 1'b0;
  logic trip_clr = 1'b0;
  logic out_stb, out_bit, trip_flag, ovf_evt, unf_evt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // writer control
  bit wr_on = 1'b0;
  int burst_len = 1;
  int period = 16;
  bit push_en = 1'b0;
  int exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  jitter_elastic_buf i_jitter_elastic_buf (
    .clk(clk), .rst(rst), .cfg_deep(cfg_deep), .cfg_bypass(cfg_bypass),
    .in_stb(in_stb), .in_bit(in_bit), .trip_clr(trip_clr),
    .out_stb(out_stb), .out_bit(out_bit), .trip_flag(trip_flag),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // background writer: burst_len strobes at the start of each period
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (wr_on) begin
        if (phase < burst_len) begin
          lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          in_stb = 1'b1;
          in_bit = lfsr[0];
          if (push_en) exp_q.push_back(int'(lfsr[0]));
        end else begin
          in_stb = 1'b0;
        end
        phase = (phase + 1 >= period) ? 0 : phase + 1;
      end else begin
        in_stb = 1'b0;
        phase  = 0;
      end
    end
  end

  task automatic do_reset(input bit deep);
    wr_on = 1'b0;
    cfg_deep = deep;
    cfg_bypass = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!out_stb);
  endtask

  task automatic measure(output int n);
    wait_stb();
    n = 0;
    do begin @(negedge clk); n++; end while (!out_stb && n < 100);
  endtask

  task automatic pulse_clr();
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk(trip_flag == 1'b0, "R6 trip after reset", trip_flag, 0);
    chk(out_stb == 1'b0, "R8 out_stb after reset", out_stb, 0);
    chk(ovf_evt == 1'b0 && unf_evt == 1'b0, "R9 events after reset", ovf_evt, 0);
  endtask

  task automatic t_nominal();
    int n;
    do_reset(1'b1);
    burst_len = 1; period = 16; wr_on = 1'b1;
    repeat (3) wait_stb();
    for (int i = 0; i < 8; i++) begin
      measure(n);
      chk(n == 16, "R3 nominal period", n, 16);
    end
    chk(trip_flag == 1'b0, "R3 no trip at nominal", trip_flag, 0);
    wr_on = 1'b0;
  endtask

  task automatic t_order();
    int got, exp, n;
    do_reset(1'b0);
    exp_q.delete();
    for (int i = 0; i < 16; i++) exp_q.push_back(-1);
    burst_len = 8; period = 128; push_en = 1'b1; wr_on = 1'b1;
    for (int i = 0; i < 48; i++) begin
      wait_stb();
      got = int'(out_bit);
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      if (exp >= 0) chk(got == exp, "R11 bit order", got, exp);
    end
    measure(n);
    chk(n == 16, "R11 period under bursts", n, 16);
    chk(trip_flag == 1'b0, "R11 no trip under bursts", trip_flag, 0);
    push_en = 1'b0; wr_on = 1'b0;
  endtask

  task automatic t_depth();
    int ovf_seen = 0;
    do_reset(1'b0);
    burst_len = 40; period = 640; wr_on = 1'b1;
    for (int i = 0; i < 1400; i++) begin
      @(negedge clk);
      if (ovf_evt) ovf_seen++;
    end
    chk(trip_flag == 1'b1, "R1 shallow trips", trip_flag, 1);
    chk(ovf_seen > 0, "R1 shallow overflows", ovf_seen, 1);
    wr_on = 1'b0;
    cfg_deep = 1'b1;
    repeat (3) @(negedge clk);
    pulse_clr();
    ovf_seen = 0;
    wr_on = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ovf_evt) ovf_seen++;
    end
    chk(trip_flag == 1'b0, "R1 deep holds without trip", trip_flag, 0);
    chk(ovf_seen == 0, "R1 deep no overflow", ovf_seen, 0);
    wr_on = 1'b0;
  endtask

  task automatic t_fast(input bit deep);
    int n, ovf_seen;
    do_reset(deep);
    burst_len = 1; period = 1; wr_on = 1'b1;
    repeat (300) @(negedge clk);
    measure(n);
    chk(n == 15, "R4 fast period", n, 15);
    chk(trip_flag == 1'b1, "R6 trip on fast", trip_flag, 1);
    ovf_seen = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ovf_evt) ovf_seen++;
    end
    chk(ovf_seen >= 14, "R9 overwrite pulses at full", ovf_seen, 15);
    wr_on = 1'b0;
  endtask

  task automatic t_slow();
    int n, b0;
    do_reset(1'b0);
    repeat (700) @(negedge clk);
    measure(n);
    chk(n == 17, "R5 slow period", n, 17);
    chk(trip_flag == 1'b1, "R6 trip on slow", trip_flag, 1);
    chk(unf_evt == 1'b1, "R10 underflow pulse with strobe", unf_evt, 1);
    b0 = int'(out_bit);
    wait_stb();
    chk(int'(out_bit) == b0, "R10 bit repeated", out_bit, b0);
  endtask

  task automatic t_trip_clr();
    // buffer still drained from t_slow
    wait_stb();
    repeat (5) @(negedge clk);
    pulse_clr();
    chk(trip_flag == 1'b0, "R7 clear between trips", trip_flag, 0);
    wait_stb();
    chk(trip_flag == 1'b1, "R7 flag set again", trip_flag, 1);
    repeat (16) @(negedge clk);
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    chk(out_stb == 1'b1, "R7 clear aligned with strobe", out_stb, 1);
    chk(trip_flag == 1'b1, "R7 set wins over clear", trip_flag, 1);
  endtask

  task automatic t_restart();
    int n, unf_seen;
    cfg_bypass = 1'b1;
    repeat (2) @(negedge clk);
    cfg_bypass = 1'b0;
    measure(n);
    chk(n == 16, "R8 recentred period", n, 16);
    unf_seen = 0;
    for (int i = 0; i < 10; i++) begin
      wait_stb();
      if (unf_evt) unf_seen++;
    end
    chk(unf_seen == 0, "R8 no underflow after recentre", unf_seen, 0);
  endtask

  task automatic t_bypass();
    logic ps, pb;
    int bad_stb = 0, bad_bit = 0, ev = 0;
    do_reset(1'b0);
    cfg_bypass = 1'b1;
    burst_len = 3; period = 7; wr_on = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk);
      ps = in_stb; pb = in_bit;
      @(negedge clk);
      if (out_stb !== ps) bad_stb++;
      if (out_bit !== pb) bad_bit++;
      if (ovf_evt || unf_evt) ev++;
    end
    chk(bad_stb == 0, "R2 strobe passthrough", bad_stb, 0);
    chk(bad_bit == 0, "R2 bit passthrough", bad_bit, 0);
    chk(ev == 0, "R2 no events in bypass", ev, 0);
    wr_on = 1'b0;
    cfg_bypass = 1'b0;
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_order();
    t_depth();
    t_fast(1'b0);
    t_fast(1'b1);
    t_slow();
    t_trip_clr();
    t_restart();
    t_bypass();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule